// File: doc/BRIEF.md
# Byte-Addressable General Register File

This block is the register storage behind a 16-bit execution datapath. It holds eight 16-bit registers. Indexes 0 to 3 are general-purpose data registers (accumulator, base, count, data). Indexes 4 to 7 are pointer and index registers (stack pointer, frame base pointer, source index, destination index). An operand fetch reads two registers at once through two independent read ports. A result goes back through one write port, which updates the storage on the rising clock edge.

Every access gives a register index and an access mode. A general register can be handled as a full word or as either 8-bit half. The halves are views of the same storage as the word, so a write to one half leaves the other half as it was. Pointer and index registers take word access only. A write that asks for a half of one of them is refused. The block reports each refused write on a one-cycle flag, so the surrounding control logic can raise a fault.

Top module: `gpr_file`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight registers are cleared to zero. After reset, every read in every mode returns 0 and `wr_illegal` is 0.
- R2: When `wr_en` is 1 and the mode is word (code 00), `wr_data` is stored whole into the register at `wr_idx` (0 to 7) at the rising edge. A word read (code 00) of that index returns it from the following cycle.
- R3: A low-half write (mode 01) to a general register (index 0 to 3) stores `wr_data[7:0]` into bits 7:0 of that register. Bits 15:8 keep their value.
- R4: A high-half write (mode 10) to a general register stores `wr_data[7:0]` into bits 15:8 of that register. Bits 7:0 keep their value.
- R5: A low-half read (mode 01) of a general register returns its bits 7:0 in bits 7:0 of the read bus. A high-half read (mode 10) returns its bits 15:8 in bits 7:0 of the read bus. In both cases bits 15:8 of the read bus are zero.
- R6: A write with `wr_en` at 1 is refused when it uses mode 01 or 10 on an index from 4 to 7, or mode 11 on any index. A refused write changes no register, and `wr_illegal` is 1 for exactly the cycle after that edge.
- R7: A read in mode 01 or 10 of an index from 4 to 7, or any read in mode 11, returns zero.
- R8: The two read ports are independent. Each port returns its own index and mode in the same cycle, without regard to the other port.
- R9: Reads are combinational from the stored state. A read of a register that is being written in the same cycle returns the value held before that write.
- R10: While `wr_en` is 0, no register changes and `wr_illegal` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index (0-3 general, 4-7 pointer/index) |
| wr_mode | input | 2 | Write mode: 00 word, 01 low half, 10 high half, 11 reserved |
| wr_data | input | 16 | Write data; halves take bits 7:0 |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_mode | input | 2 | Read port 0 mode, same encoding as the write mode |
| rd0_data | output | 16 | Read port 0 data |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_mode | input | 2 | Read port 1 mode, same encoding as the write mode |
| rd1_data | output | 16 | Read port 1 data |
| wr_illegal | output | 1 | One-cycle pulse after a refused write |

## Verification
The assertions take for granted that the index and mode inputs are never unknown at a rising edge. They also take for granted that the whole write request is stable around that edge. The stimulus meets this by changing every input only at the falling edge, with every index and mode a defined value. The stimulus uses the reserved mode code and half modes on pointer indexes on purpose, so that the refusal checks are exercised. This keeps the inputs inside the assertions' assumptions, because every mode value has a defined response.

// File: rtl/gpr_pkg.sv
// Package: shared access-mode encoding for the register file.
// Assumes: the register width is even, so that it splits into two halves.
package gpr_pkg;

    typedef enum logic [1:0] {
        ACC_WORD = 2'b00,
        ACC_LOW  = 2'b01,
        ACC_HIGH = 2'b10,
        ACC_RSVD = 2'b11
    } acc_mode_e;

endpackage

// File: rtl/gpr_word_cell.sv
// Module: one register of the file, stored as two independently enabled halves.
// Assumes: half_we is already qualified by the decoder. d carries the data
// already steered into the half lane being written.
module gpr_word_cell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   half_we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int HALF = W / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        // Update one half on its own enable, and clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[h*HALF +: HALF] <= '0;
            else if (half_we[h])
                q[h*HALF +: HALF] <= d[h*HALF +: HALF];
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> q == '0);
    a_r3_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        half_we == 2'b01 |=> q[W-1:HALF] == $past(q[W-1:HALF]));
    a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        half_we == 2'b10 |=> q[HALF-1:0] == $past(q[HALF-1:0]));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        half_we == 2'b00 |=> $stable(q));

endmodule

// File: rtl/gpr_write_decode.sv
// Module: turns a write request into per-register half enables and lane data.
// It also decides whether the request is refused.
// Assumes: registers below NUM_GEN allow half access and all others are word-only.
module gpr_write_decode
    import gpr_pkg::*;
#(
    parameter int W       = 16,
    parameter int NUM_GEN = 4,
    parameter int NREG    = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_mode,
    input  logic [W-1:0]     wr_data,
    output logic [1:0]       half_we [NREG],
    output logic [W-1:0]     lane_data,
    output logic             reject
);
    localparam int HALF = W / 2;

    acc_mode_e  mode;
    logic       is_gen;
    logic [1:0] half_sel;
    logic [NREG-1:0] hit;

    assign mode   = acc_mode_e'(wr_mode);
    assign is_gen = int'(wr_idx) < NUM_GEN;

    // Pick which halves the mode writes and whether the request is legal.
    always_comb begin
        half_sel = 2'b00;
        reject   = 1'b0;
        unique case (mode)
            ACC_WORD: half_sel = 2'b11;
            ACC_LOW:  if (is_gen) half_sel = 2'b01; else reject = 1'b1;
            ACC_HIGH: if (is_gen) half_sel = 2'b10; else reject = 1'b1;
            default:  reject = 1'b1;
        endcase
    end

    // Steer the low bits of the data into both lanes for half writes.
    always_comb begin
        if (mode == ACC_WORD)
            lane_data = wr_data;
        else
            lane_data = {wr_data[HALF-1:0], wr_data[HALF-1:0]};
    end

    for (genvar r = 0; r < NREG; r++) begin : g_en
        assign hit[r]     = wr_en && (int'(wr_idx) == r);
        assign half_we[r] = hit[r] ? half_sel : 2'b00;
    end

    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    a_r6_refused_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> half_we[wr_idx] == 2'b00);

endmodule

// File: rtl/gpr_read_port.sv
// Module: one combinational read port with word and half extraction.
// Assumes: regs reflects the stored state before any pending write.
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int W       = 16,
    parameter int NUM_GEN = 4,
    parameter int NREG    = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     regs [NREG],
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       mode,
    output logic [W-1:0]     data
);
    localparam int HALF = W / 2;

    logic [W-1:0] word;
    logic         is_gen;
    acc_mode_e    m;

    assign word   = regs[idx];
    assign is_gen = int'(idx) < NUM_GEN;
    assign m      = acc_mode_e'(mode);

    // Format the selected register according to the access mode.
    always_comb begin
        data = '0;
        unique case (m)
            ACC_WORD: data = word;
            ACC_LOW:  if (is_gen) data[HALF-1:0] = word[HALF-1:0];
            ACC_HIGH: if (is_gen) data[HALF-1:0] = word[W-1:HALF];
            default:  data = '0;
        endcase
    end

    a_r5_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (m == ACC_LOW || m == ACC_HIGH) |-> data[W-1:HALF] == '0);
    a_r7_ptr_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((m != ACC_WORD && !is_gen) || m == ACC_RSVD) |-> data == '0);

endmodule

// File: rtl/gpr_file.sv
// Module: a register file of general and pointer/index registers, with two read
// ports and one write port. General registers also allow half access.
// Assumes: synchronous active-low reset, and inputs stable around the rising edge.
module gpr_file
    import gpr_pkg::*;
#(
    parameter int W       = 16,
    parameter int NUM_GEN = 4,
    parameter int NUM_PTR = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [$clog2(NUM_GEN+NUM_PTR)-1:0]   wr_idx,
    input  logic [1:0]                           wr_mode,
    input  logic [W-1:0]                         wr_data,
    input  logic [$clog2(NUM_GEN+NUM_PTR)-1:0]   rd0_idx,
    input  logic [1:0]                           rd0_mode,
    output logic [W-1:0]                         rd0_data,
    input  logic [$clog2(NUM_GEN+NUM_PTR)-1:0]   rd1_idx,
    input  logic [1:0]                           rd1_mode,
    output logic [W-1:0]                         rd1_data,
    output logic                                 wr_illegal
);
    localparam int NREG  = NUM_GEN + NUM_PTR;
    localparam int IDX_W = $clog2(NREG);

    logic [1:0]   half_we [NREG];
    logic [W-1:0] lane_data;
    logic         reject;
    logic [W-1:0] regs [NREG];

    gpr_write_decode #(.W(W), .NUM_GEN(NUM_GEN), .NREG(NREG), .IDX_W(IDX_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_mode(wr_mode), .wr_data(wr_data), .half_we(half_we),
        .lane_data(lane_data), .reject(reject)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        gpr_word_cell #(.W(W)) u_cell (
            .clk(clk), .rst_n(rst_n), .half_we(half_we[r]),
            .d(lane_data), .q(regs[r])
        );
    end

    gpr_read_port #(.W(W), .NUM_GEN(NUM_GEN), .NREG(NREG), .IDX_W(IDX_W)) u_rd0 (
        .clk(clk), .rst_n(rst_n), .regs(regs), .idx(rd0_idx),
        .mode(rd0_mode), .data(rd0_data)
    );

    gpr_read_port #(.W(W), .NUM_GEN(NUM_GEN), .NREG(NREG), .IDX_W(IDX_W)) u_rd1 (
        .clk(clk), .rst_n(rst_n), .regs(regs), .idx(rd1_idx),
        .mode(rd1_mode), .data(rd1_data)
    );

    // Flag a refused write for the single cycle that follows it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_illegal <= 1'b0;
        else
            wr_illegal <= wr_en && reject;
    end

    a_r6_flag_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_mode != 2'b00 && int'(wr_idx) >= NUM_GEN) || wr_mode == 2'b11))
        |=> wr_illegal);
    a_r10_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_illegal);
    a_r9_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd0_idx == wr_idx && rd0_mode == 2'b00)
        |-> rd0_data == regs[wr_idx]);

endmodule

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0, rd0_idx = '0, rd1_idx = '0;
    logic [1:0]  wr_mode = '0, rd0_mode = '0, rd1_mode = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd0_data, rd1_data;
    logic        wr_illegal;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    int unsigned model [8];
    string       last_tag [8];
    bit          exp_ill = 0;
    string       ill_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_file u_gpr_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_mode(wr_mode), .wr_data(wr_data), .rd0_idx(rd0_idx),
        .rd0_mode(rd0_mode), .rd0_data(rd0_data), .rd1_idx(rd1_idx),
        .rd1_mode(rd1_mode), .rd1_data(rd1_data), .wr_illegal(wr_illegal)
    );

    function automatic int unsigned ref_read(int idx, int mode);
        if (mode == 0) return model[idx];
        if (mode == 3 || idx >= 4) return 0;
        if (mode == 1) return model[idx] & 32'hFF;
        return (model[idx] >> 8) & 32'hFF;
    endfunction

    function automatic string read_tag(int idx, int mode, bit same);
        if (same) return "R9";
        if (mode == 3 || (mode != 0 && idx >= 4)) return "R7";
        if (mode != 0) return "R5";
        return last_tag[idx];
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check, then update the model at the rising edge.
    task automatic step(bit en, int wi, int wm, int unsigned wd,
                        int r0i, int r0m, int r1i, int r1m);
        bit bad;
        @(negedge clk);
        wr_en = en; wr_idx = 3'(wi); wr_mode = 2'(wm); wr_data = 16'(wd);
        rd0_idx = 3'(r0i); rd0_mode = 2'(r0m); rd1_idx = 3'(r1i); rd1_mode = 2'(r1m);
        #1;
        if (rst_n) begin
            check(read_tag(r0i, r0m, en && wi == r0i), rd0_data, ref_read(r0i, r0m));
            check({"R8/", read_tag(r1i, r1m, en && wi == r1i)}, rd1_data, ref_read(r1i, r1m));
            check(ill_tag, wr_illegal, exp_ill);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin model[i] = 0; last_tag[i] = "R1"; end
            exp_ill = 0; ill_tag = "R1";
        end else begin
            bad = (wm == 3) || (wm != 0 && wi >= 4);
            if (en && !bad) begin
                if (wm == 0) begin model[wi] = wd & 32'hFFFF; last_tag[wi] = "R2"; end
                else if (wm == 1) begin model[wi] = (model[wi] & 32'hFF00) | (wd & 32'hFF); last_tag[wi] = "R3"; end
                else begin model[wi] = (model[wi] & 32'h00FF) | ((wd & 32'hFF) << 8); last_tag[wi] = "R4"; end
            end
            exp_ill = en && bad;
            ill_tag = (en && bad) ? "R6" : "R10";
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        // R1: all registers read zero after reset, both ports, all modes
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, i, 0, i, 1);
        step(0, 0, 0, 0, 2, 2, 5, 3);
        // R2: word write to every index
        for (int i = 0; i < 8; i++) step(1, i, 0, 16'h1111 * (i + 1) + 16'h0A05, (i + 7) % 8, 0, i, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, i, 0, i, 0);
        // R3, R4: half writes keep the other half
        step(1, 1, 1, 16'hBEEF, 1, 0, 1, 1);
        step(1, 2, 2, 16'h12C3, 1, 0, 1, 2);
        step(0, 0, 0, 0, 2, 0, 2, 1);
        step(0, 0, 0, 0, 2, 2, 1, 1);
        // R6: refused writes to pointers and reserved mode
        step(1, 5, 1, 16'hFFFF, 5, 0, 5, 1);
        step(1, 6, 2, 16'hFFFF, 6, 0, 5, 0);
        step(1, 0, 3, 16'hFFFF, 0, 0, 6, 0);
        step(0, 0, 0, 0, 0, 0, 0, 3);
        // R9: read while writing the same register
        step(1, 3, 0, 16'h5A5A, 3, 0, 3, 2);
        step(0, 0, 0, 0, 3, 0, 3, 1);
        // random mix
        for (int n = 0; n < 600; n++)
            step($urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom_range(0, 3),
                 $urandom_range(0, 65535), $urandom_range(0, 7), $urandom_range(0, 3),
                 $urandom_range(0, 7), $urandom_range(0, 3));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule